// File: doc/BRIEF.md
# Reference Tracking Code Controller

This block is a small synchronous controller. It keeps a trim code for a switched resistor network, and that network sets the tracked reference level used in the feedback loop of a boost converter. Elsewhere a comparator checks the tracked reference against the lowest sink voltage seen across all LED strings. That comparator gives this block a direction flag. The current sinks give it a flag that says the string current has reached its target. A dimming enable says whether the strings are being driven at the moment.

The code moves only while dimming is on and the sink current is confirmed. In that condition each pulse of an update strobe moves the code one step up or one step down. The direction flag picks which way. When the current is not yet confirmed, the code stays where it is. While dimming is off, tracking stops, so the stored code alone sets the converter output through the dimming gaps. The three control inputs are asynchronous to the block clock and pass through synchronising flops before any use. The present control state is shown on a 2-bit output.

Top module: `ref_track_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the code becomes 8 and `state_o` becomes 2'b00 (idle).
- R2: With dimming high, current-ok high and ref-high low, `state_o` is 2'b01 (up). Each clock edge with `tick_i` high then raises the code by exactly 1.
- R3: With dimming high, current-ok high and ref-high high, `state_o` is 2'b10 (down). Each clock edge with `tick_i` high then lowers the code by exactly 1.
- R4: With dimming high and current-ok low, `state_o` is 2'b00 (idle) and ticks leave the code unchanged.
- R5: With dimming low, `state_o` is 2'b11 (hold) and ticks leave the code unchanged. The code is kept across repeated dimming off/on cycles.
- R6: On a clock edge with `tick_i` low, the code does not change in any state.
- R7: The code saturates at 15 when stepping up and at 0 when stepping down. It never wraps.
- R8: A change on a control input is applied at a clock edge. `state_o` first shows the change after the third clock edge that follows: two synchroniser stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| dim_en_i | input | 1 | Dimming enable (asynchronous) |
| cur_ok_i | input | 1 | String current reached flag (asynchronous) |
| ref_high_i | input | 1 | Tracked reference is above the minimum sink voltage (asynchronous) |
| tick_i | input | 1 | Update strobe, one clock wide, in the clock domain |
| code_o | output | 4 | Trim code for the resistor network |
| state_o | output | 2 | 00 idle, 01 up, 10 down, 11 hold |

## Verification
The hardest conditions to reach from the ports are the two saturation limits. Reaching them needs a long run of ticks in one direction. The bench sends more ticks than the range needs, first upward past 15 and then downward past 0, and checks the clamped value. Holding the code across dimming gaps needs ticks while dimming is off. So the bench pulses the strobe inside each gap, over several off/on cycles, and checks the code is unchanged. Synchroniser latency is checked by sampling `state_o` directly just before and just after the third edge that follows an input change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_UP   = 2'b01,
      ST_DOWN = 2'b10,
      ST_HOLD = 2'b11
   } trk_state_t;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rtc_sync needs at least two stages");
      end
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[STAGES-2:0], async_i[b]};
         end
         assign sync_o[b] = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rtc_fsm.sv
module rtc_fsm
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       dim_s,
   input  logic       cur_s,
   input  logic       high_s,
   output trk_state_t state_q
);
   trk_state_t state_d;

   always_comb begin
      if (!dim_s)       state_d = ST_HOLD;
      else if (!cur_s)  state_d = ST_IDLE;
      else if (high_s)  state_d = ST_DOWN;
      else              state_d = ST_UP;
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   AST_DIM_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!dim_s) |=> (state_q == ST_HOLD)); // R5
   AST_NO_CUR_IDLE: assert property (@(posedge clk) disable iff (rst)
      (dim_s && !cur_s) |=> (state_q == ST_IDLE)); // R4
endmodule

// File: rtl/rtc_code.sv
module rtc_code
   import rtc_pkg::*;
#(
   parameter int CODE_W     = 4,
   parameter int RESET_CODE = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  trk_state_t        state_i,
   output logic [CODE_W-1:0] code_q
);
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_MIN = '0;
   localparam logic [CODE_W-1:0] CODE_RST = RESET_CODE[CODE_W-1:0];

   generate
      if (CODE_W < 1) begin : g_bad_width
         $error("rtc_code width must be positive");
      end
      if (RESET_CODE < 0 || RESET_CODE > (2**CODE_W - 1)) begin : g_bad_reset
         $error("rtc_code reset value out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= CODE_RST;
      end else if (tick_i) begin
         case (state_i)
            ST_UP:   if (code_q != CODE_MAX) code_q <= code_q + 1'b1;
            ST_DOWN: if (code_q != CODE_MIN) code_q <= code_q - 1'b1;
            default: code_q <= code_q;
         endcase
      end
   end

   AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (rst)
      (!tick_i) |=> $stable(code_q)); // R6
   AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
      (tick_i && state_i == ST_UP && code_q != CODE_MAX) |=> (code_q == $past(code_q) + 1'b1)); // R2
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
      (tick_i && state_i == ST_DOWN && code_q != CODE_MIN) |=> (code_q == $past(code_q) - 1'b1)); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (state_i == ST_UP && code_q == CODE_MAX) |=> (code_q == CODE_MAX)); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (state_i == ST_DOWN && code_q == CODE_MIN) |=> (code_q == CODE_MIN)); // R7
   AST_PASSIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (state_i == ST_IDLE || state_i == ST_HOLD) |=> $stable(code_q)); // R4 R5
endmodule

// File: rtl/ref_track_ctrl.sv
module ref_track_ctrl
   import rtc_pkg::*;
#(
   parameter int CODE_W      = 4,
   parameter int RESET_CODE  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dim_en_i,
   input  logic              cur_ok_i,
   input  logic              ref_high_i,
   input  logic              tick_i,
   output logic [CODE_W-1:0] code_o,
   output logic [1:0]        state_o
);
   localparam int NUM_CTRL = 3;

   logic [NUM_CTRL-1:0] ctrl_s;
   trk_state_t          state_q;

   rtc_sync #(.WIDTH(NUM_CTRL), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i ({dim_en_i, cur_ok_i, ref_high_i}),
      .sync_o  (ctrl_s)
   );

   rtc_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .dim_s   (ctrl_s[2]),
      .cur_s   (ctrl_s[1]),
      .high_s  (ctrl_s[0]),
      .state_q (state_q)
   );

   rtc_code #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_code (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (tick_i),
      .state_i (state_q),
      .code_q  (code_o)
   );

   assign state_o = state_q;

   AST_RESET_VALUE: assert property (@(posedge clk)
      rst |=> (code_o == RESET_CODE[CODE_W-1:0] && state_o == 2'b00)); // R1
endmodule

// File: tb/ref_track_ctrl_test.sv
module ref_track_ctrl_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       dim_en_i = 1'b0;
   logic       cur_ok_i = 1'b0;
   logic       ref_high_i = 1'b0;
   logic       tick_i = 1'b0;
   logic [3:0] code_o;
   logic [1:0] state_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [3:0] code;
      logic [1:0] state;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   ref_track_ctrl uut (
      .clk(clk), .rst(rst), .dim_en_i(dim_en_i), .cur_ok_i(cur_ok_i),
      .ref_high_i(ref_high_i), .tick_i(tick_i), .code_o(code_o), .state_o(state_o)
   );

   always #5 clk = ~clk;

   task automatic compare(input logic [3:0] ec, input logic [1:0] es, input string tag);
      checks++;
      if (code_o !== ec || state_o !== es) begin
         errors++;
         $display("FAIL %s: code %0d state %b, expected code %0d state %b",
                  tag, code_o, state_o, ec, es);
      end
   endtask

   // monitor: consumes expected items one cycle after they are queued
   initial begin
      forever begin
         @(posedge clk);
         #3;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compare(e.code, e.state, e.tag);
         end
      end
   end

   task automatic expect_out(input logic [3:0] ec, input logic [1:0] es, input string tag);
      exp_t e;
      e.code = ec; e.state = es; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic pulse_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_i = 1'b1;
         @(negedge clk) tick_i = 1'b0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_out(4'd8, 2'b00, "R1 reset state");
      @(negedge clk) rst = 1'b0;

      settle();
      pulse_ticks(3);
      expect_out(4'd8, 2'b11, "R5 dimming off holds code");

      dim_en_i = 1'b1; cur_ok_i = 1'b0;
      settle();
      pulse_ticks(2);
      expect_out(4'd8, 2'b00, "R4 current not confirmed idle");

      // R8: latency of a control change through sync and state register
      @(negedge clk) cur_ok_i = 1'b1; ref_high_i = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      compare(4'd8, 2'b00, "R8 state before third edge");
      @(posedge clk); #1;
      compare(4'd8, 2'b01, "R8 state after third edge");

      settle();
      expect_out(4'd8, 2'b01, "R6 no tick leaves code");
      pulse_ticks(3);
      expect_out(4'd11, 2'b01, "R2 up tracking steps");
      pulse_ticks(10);
      expect_out(4'd15, 2'b01, "R7 upper saturation");

      ref_high_i = 1'b1;
      settle();
      pulse_ticks(1);
      expect_out(4'd14, 2'b10, "R3 down tracking step");
      pulse_ticks(20);
      expect_out(4'd0, 2'b10, "R7 lower saturation");

      ref_high_i = 1'b0;
      settle();
      pulse_ticks(5);
      expect_out(4'd5, 2'b01, "R2 up from zero");

      for (int k = 0; k < 3; k++) begin
         dim_en_i = 1'b0;
         settle();
         pulse_ticks(4);
         expect_out(4'd5, 2'b11, "R5 code held in dimming gap");
         dim_en_i = 1'b1;
         settle();
         expect_out(4'd5, 2'b01, "R5 code kept after dimming returns");
      end

      pulse_ticks(1);
      expect_out(4'd6, 2'b01, "R2 tracking resumes after gaps");

      cur_ok_i = 1'b0;
      settle();
      pulse_ticks(3);
      expect_out(4'd6, 2'b00, "R4 idle after current lost");

      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      expect_out(4'd8, 2'b00, "R1 reset from running state");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule